// File: doc/BRIEF.md
# Mini UART Register Front-End

This block is the register side of a small auxiliary serial port. A host reaches it through a 32-bit, word-only register bus. Received bytes come in over a valid/ready byte port and wait in a circular buffer of parameterised depth. Bytes written by the host leave on a one-cycle transmit strobe. The block builds fixed-format identify, line-status and extended-status words from the buffer fill level. It also drives one level-sensitive interrupt line.

The host pops received bytes by reading the data register. It can empty the buffer at once by writing the identify register. Two interrupt sources are gated by an enable register. The receive source is pending while enabled and the buffer holds data. The transmit source is pending whenever it is enabled, because the transmit path here never backs up. Baud, line control, modem control and scratch storage are not built: those offsets read zero and writes to them change nothing.

Top module: `mu_regfront`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty, both interrupt enables are clear, `irq` is low, `rx_ready` is high and the line status reads 0x60.
- R2: A write to offset 0x44 keeps only data bits 1:0 as the enables (bit 0 receive, bit 1 transmit). A read of 0x44 returns 0xC0 ORed with those two bits.
- R3: `irq` is high exactly when (receive enable and fill count nonzero) or transmit enable. Offset 0x00 reads that bit at position 0 and zero elsewhere.
- R4: Offset 0x48 reads 0xC0, plus 0x04 when the buffer holds data or 0x02 when it is empty, plus 0x01 only when `irq` is low.
- R5: A write to 0x48 with data bit 1 set makes the buffer empty on the next cycle. A byte offered in that same cycle is dropped. A write with bit 1 clear leaves the buffer alone.
- R6: Offset 0x54 reads 0x60 with bit 0 set when the buffer holds data. Offset 0x60 always reads 0x3 and offset 0x04 always reads 0x1.
- R7: Offset 0x64 reads 0x30E when empty. When it holds data it reads 0x30F with the fill count placed from bit 16 upward.
- R8: A read of 0x40 returns the oldest byte and pops it, in arrival order across pointer wraparound. A read while empty returns the byte at the current pointer slot and changes no state.
- R9: `rx_ready` is high while the fill count is below DEPTH. A byte offered while it is low is not stored, and the count never exceeds DEPTH.
- R10: A write to 0x40 raises `tx_strobe` for exactly the next cycle, with `tx_byte` equal to the written bits 7:0.
- R11: Offsets without a function (0x4C, 0x50, 0x58, 0x5C, 0x68 and all other offsets) read zero and ignore writes. Any access whose byte enables are not all set reads zero and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | 8 | Receive byte |
| rx_ready | output | 1 | Buffer has room; a byte is taken when valid and ready |
| tx_strobe | output | 1 | One-cycle pulse per transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the buffer after the read pointer has moved off slot zero, so the write slot wraps. A design that skips the modulo on pointer plus count would store bytes outside the ring and drain them out of order. It reads the data register while empty and checks that the same stale byte comes back twice with the status unchanged; a design that pops unconditionally would move the pointer or underflow the count. It offers a byte while full and a byte during a flush, which a design with the wrong priority would store. It also checks that the transmit enable alone raises the interrupt and clears the identify bit 0, which a design that ties transmit pending to buffer state would miss.

// File: rtl/mu_pkg.sv
// Package: register offsets and shared constants for the mini UART front-end.
// Assumes an 8-bit byte offset inside a 256-byte register window.
package mu_pkg;
    localparam int          ADDR_W     = 8;
    localparam int          DATA_W     = 32;
    localparam logic [7:0]  OFS_IRQSUM = 8'h00;
    localparam logic [7:0]  OFS_ENABLE = 8'h04;
    localparam logic [7:0]  OFS_DATA   = 8'h40;
    localparam logic [7:0]  OFS_IEN    = 8'h44;
    localparam logic [7:0]  OFS_IDENT  = 8'h48;
    localparam logic [7:0]  OFS_LSTAT  = 8'h54;
    localparam logic [7:0]  OFS_CTRL   = 8'h60;
    localparam logic [7:0]  OFS_XSTAT  = 8'h64;
    localparam logic [31:0] IDENT_BASE = 32'h0000_00C0;
    localparam logic [31:0] IEN_BASE   = 32'h0000_00C0;
    localparam logic [31:0] LSTAT_BASE = 32'h0000_0060;
    localparam logic [31:0] XSTAT_BASE = 32'h0000_030E;
    localparam logic [31:0] CTRL_VAL   = 32'h0000_0003;
    localparam logic [31:0] ENABLE_VAL = 32'h0000_0001;
    localparam int          XSTAT_CNT_LSB = 16;

    // Decoded bus strobes for one cycle
    typedef struct packed {
        logic pop;
        logic flush;
        logic ien_we;
        logic tx_we;
    } mu_strobe_t;
endpackage

// File: rtl/mu_rxfifo.sv
// Circular receive buffer: a read pointer and a fill count; the write slot is
// pointer plus count modulo DEPTH. Flush zeroes the count and wins over a push.
// Pop while empty leaves all state unchanged. Storage is not reset.
module mu_rxfifo #(
    parameter int DEPTH = 8,
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          pop,
    input  logic          flush,
    output logic [7:0]    head_byte,
    output logic [CW-1:0] count,
    output logic [PW-1:0] rd_ptr,
    output logic          has_room
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW:0]   DEPTH_X = (CW+1)'(DEPTH);

    logic [7:0]    store [DEPTH];
    logic [CW:0]   slot_sum;
    logic [PW-1:0] wr_slot;
    logic [PW-1:0] ptr_next;
    logic          push_ok;
    logic          pop_ok;

    // Qualify the handshake and the pop
    always_comb begin
        has_room = (count < DEPTH_C);
        push_ok  = push && has_room && !flush;
        pop_ok   = pop && (count != '0);
    end

    // Write slot and next read pointer, both wrapped at DEPTH
    always_comb begin
        slot_sum = (CW+1)'(rd_ptr) + (CW+1)'(count);
        if (slot_sum >= DEPTH_X) begin
            slot_sum = slot_sum - DEPTH_X;
        end
        wr_slot = PW'(slot_sum);
        if (rd_ptr == PW'(DEPTH - 1)) begin
            ptr_next = '0;
        end else begin
            ptr_next = rd_ptr + PW'(1);
        end
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            count <= '0;
        end else begin
            if (pop_ok) begin
                rd_ptr <= ptr_next;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Byte storage
    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_slot] <= push_byte;
        end
    end

    assign head_byte = store[rd_ptr];
endmodule

// File: rtl/mu_irqctl.sv
// Interrupt enable register and pending logic. Receive pends while enabled and
// data is present; transmit pends whenever enabled. Output is the OR.
module mu_irqctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ien_we,
    input  logic [1:0] ien_wdata,
    input  logic       nonempty,
    output logic [1:0] ien,
    output logic       irq
);
    logic rx_pend;
    logic tx_pend;

    // Enable register, only the two defined bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 2'b00;
        end else if (ien_we) begin
            ien <= ien_wdata;
        end
    end

    // Pending sources and the level output
    always_comb begin
        rx_pend = ien[0] && nonempty;
        tx_pend = ien[1];
        irq     = rx_pend || tx_pend;
    end
endmodule

// File: rtl/mu_rdmux.sv
// Read data composition. Fixed constants plus live flags; zero for unmapped
// offsets and when no full-word read is in progress.
module mu_rdmux #(
    parameter int CW = 4
) (
    input  logic          rd_en,
    input  logic [7:0]    addr,
    input  logic          irq,
    input  logic [1:0]    ien,
    input  logic [7:0]    head_byte,
    input  logic [CW-1:0] count,
    output logic [31:0]   rdata
);
    import mu_pkg::*;

    logic nonempty;

    // Select the word for the addressed register
    always_comb begin
        nonempty = (count != '0);
        rdata    = '0;
        if (rd_en) begin
            case (addr)
                OFS_IRQSUM: rdata = {31'b0, irq};
                OFS_ENABLE: rdata = ENABLE_VAL;
                OFS_DATA:   rdata = {24'b0, head_byte};
                OFS_IEN:    rdata = IEN_BASE | {30'b0, ien};
                OFS_IDENT:  rdata = IDENT_BASE
                                  | (nonempty ? 32'h4 : 32'h2)
                                  | {31'b0, !irq};
                OFS_LSTAT:  rdata = LSTAT_BASE | {31'b0, nonempty};
                OFS_CTRL:   rdata = CTRL_VAL;
                OFS_XSTAT:  rdata = nonempty
                                  ? (XSTAT_BASE | 32'h1 | (32'(count) << XSTAT_CNT_LSB))
                                  : XSTAT_BASE;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mu_regfront.sv
// Mini UART register front-end top. Decodes full-word bus accesses, feeds the
// receive buffer, keeps the interrupt enables and registers the transmit strobe.
// Assumes one access per cycle and reads without wait states.
module mu_regfront #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        rx_ready,
    output logic        tx_strobe,
    output logic [7:0]  tx_byte,
    output logic        irq
);
    import mu_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          acc_full;
    logic          rd_en;
    logic          wr_en;
    mu_strobe_t    stb;
    logic [7:0]    head_byte;
    logic [CW-1:0] count;
    logic [PW-1:0] rd_ptr;
    logic [1:0]    ien;
    logic          unused_wbits;

    assign unused_wbits = ^bus_wdata[31:8];

    // Full-word access decode into per-register strobes
    always_comb begin
        acc_full   = bus_sel && (bus_be == 4'hF);
        rd_en      = acc_full && !bus_wr;
        wr_en      = acc_full && bus_wr;
        stb.pop    = rd_en && (bus_addr == OFS_DATA);
        stb.flush  = wr_en && (bus_addr == OFS_IDENT) && bus_wdata[1];
        stb.ien_we = wr_en && (bus_addr == OFS_IEN);
        stb.tx_we  = wr_en && (bus_addr == OFS_DATA);
    end

    mu_rxfifo #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) i_rxfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_byte (rx_byte),
        .pop       (stb.pop),
        .flush     (stb.flush),
        .head_byte (head_byte),
        .count     (count),
        .rd_ptr    (rd_ptr),
        .has_room  (rx_ready)
    );

    mu_irqctl i_irqctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_we    (stb.ien_we),
        .ien_wdata (bus_wdata[1:0]),
        .nonempty  (count != '0),
        .ien       (ien),
        .irq       (irq)
    );

    mu_rdmux #(.CW(CW)) i_rdmux (
        .rd_en     (rd_en),
        .addr      (bus_addr),
        .irq       (irq),
        .ien       (ien),
        .head_byte (head_byte),
        .count     (count),
        .rdata     (bus_rdata)
    );

    // Transmit strobe: one cycle after a data write, byte held until the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= 8'h00;
        end else begin
            tx_strobe <= stb.tx_we;
            if (stb.tx_we) begin
                tx_byte <= bus_wdata[7:0];
            end
        end
    end
endmodule

// File: rtl/mu_regfront_chk.sv
// Assertion checker for mu_regfront, attached by bind. Observes ports and the
// internal enable, count and pointer state.
module mu_regfront_chk #(
    parameter int DEPTH = 8,
    parameter int PW    = 3,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [7:0]    bus_addr,
    input logic [3:0]    bus_be,
    input logic [31:0]   bus_wdata,
    input logic          rx_ready,
    input logic          tx_strobe,
    input logic [7:0]    tx_byte,
    input logic          irq,
    input logic [1:0]    ien,
    input logic [CW-1:0] count,
    input logic [PW-1:0] rd_ptr
);
    logic wr_data;
    logic wr_flush;
    logic rd_data;

    // Full-word access classes seen at the bus
    always_comb begin
        wr_data  = bus_sel && bus_wr && (bus_be == 4'hF) && (bus_addr == 8'h40);
        wr_flush = bus_sel && bus_wr && (bus_be == 4'hF) && (bus_addr == 8'h48) && bus_wdata[1];
        rd_data  = bus_sel && !bus_wr && (bus_be == 4'hF) && (bus_addr == 8'h40);
    end

    AST_TX_PEND_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ien[1] |-> irq); // R3

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flush |=> (count == '0)); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CW'(DEPTH))); // R9

    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !rx_ready); // R9

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && (count == '0)) |=> (rd_ptr == $past(rd_ptr))); // R8

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (tx_strobe && (tx_byte == $past(bus_wdata[7:0])))); // R10

    AST_TX_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> !tx_strobe); // R10
endmodule

bind mu_regfront mu_regfront_chk #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .rx_ready  (rx_ready),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .irq       (irq),
    .ien       (ien),
    .count     (count),
    .rd_ptr    (rd_ptr)
);

// File: tb/test_mu_regfront.sv
// Bench for mu_regfront: a vector table walked by one loop, then directed
// tests for buffer wrap, full, flush, transmit, partial access and reset.
module test_mu_regfront;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mu_regfront #(.DEPTH(DEPTH)) i_mu_regfront (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    // op: 0 write, 1 read and compare, 2 push receive byte
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h00, 32'h0000_0000},
        '{2'd1, 8'h54, 32'h0000_0060},
        '{2'd1, 8'h48, 32'h0000_00C3},
        '{2'd1, 8'h60, 32'h0000_0003},
        '{2'd1, 8'h04, 32'h0000_0001},
        '{2'd1, 8'h64, 32'h0000_030E},
        '{2'd1, 8'h44, 32'h0000_00C0},
        '{2'd0, 8'h44, 32'hFFFF_FFFF},
        '{2'd1, 8'h44, 32'h0000_00C3},
        '{2'd1, 8'h00, 32'h0000_0001},
        '{2'd1, 8'h48, 32'h0000_00C2},
        '{2'd0, 8'h44, 32'h0000_0001},
        '{2'd1, 8'h00, 32'h0000_0000},
        '{2'd2, 8'h00, 32'h0000_005A},
        '{2'd1, 8'h00, 32'h0000_0001},
        '{2'd1, 8'h48, 32'h0000_00C4},
        '{2'd1, 8'h54, 32'h0000_0061},
        '{2'd1, 8'h64, 32'h0001_030F},
        '{2'd2, 8'h00, 32'h0000_00A5},
        '{2'd1, 8'h64, 32'h0002_030F},
        '{2'd1, 8'h40, 32'h0000_005A},
        '{2'd1, 8'h40, 32'h0000_00A5},
        '{2'd1, 8'h54, 32'h0000_0060},
        '{2'd1, 8'h00, 32'h0000_0000},
        '{2'd1, 8'h4C, 32'h0000_0000},
        '{2'd0, 8'h68, 32'h0000_00FF},
        '{2'd1, 8'h68, 32'h0000_0000},
        '{2'd1, 8'h44, 32'h0000_00C1},
        '{2'd1, 8'h48, 32'h0000_00C3}
    };

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:               return "R3";
            8'h04, 8'h54, 8'h60: return "R6";
            8'h44:               return "R2";
            8'h48:               return "R4";
            8'h64:               return "R7";
            8'h40:               return "R8";
            default:             return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state at the ports
        @(negedge clk);
        #1;
        check("R1", "irq after reset", {31'b0, irq}, 32'h0);
        check("R1", "rx_ready after reset", {31'b0, rx_ready}, 32'h1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: bus_write(VECS[i].addr, VECS[i].data);
                2'd2: push(VECS[i].data[7:0]);
                default: begin
                    bus_read(VECS[i].addr, rd);
                    check(tag_of(VECS[i].addr), $sformatf("vector %0d", i), rd, VECS[i].data);
                end
            endcase
        end

        // R9 and R8: fill across the wrap (pointer now at slot 2), then full
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            #1 check("R9", "ready before fill push", {31'b0, rx_ready}, 32'h1);
            push(8'h10 + 8'(k));
        end
        @(negedge clk);
        #1 check("R9", "ready low when full", {31'b0, rx_ready}, 32'h0);
        push(8'hEE);
        bus_read(8'h64, rd);
        check("R9", "count held at depth", rd, 32'h0008_030F);
        for (int k = 0; k < DEPTH; k++) begin
            bus_read(8'h40, rd);
            check("R8", "drain order across wrap", rd, 32'h10 + 32'(k));
        end
        bus_read(8'h40, rd);
        check("R8", "empty read stale slot", rd, 32'h0000_0010);
        bus_read(8'h40, rd);
        check("R8", "empty read again", rd, 32'h0000_0010);
        bus_read(8'h64, rd);
        check("R8", "empty read no state change", rd, 32'h0000_030E);

        // R5 flush behaviour
        push(8'h21); push(8'h22); push(8'h23);
        bus_write(8'h48, 32'h0000_0000);
        bus_read(8'h64, rd);
        check("R5", "identify write bit1 clear", rd, 32'h0003_030F);
        bus_write(8'h48, 32'h0000_0002);
        bus_read(8'h64, rd);
        check("R5", "flush empties", rd, 32'h0000_030E);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h2;
        rx_valid = 1'b1; rx_byte = 8'h77;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
        bus_read(8'h54, rd);
        check("R5", "push during flush dropped", rd, 32'h0000_0060);

        // R10 transmit strobe
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h1234_56C3;
        #1 check("R10", "no strobe before edge", {31'b0, tx_strobe}, 32'h0);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1 check("R10", "strobe after write", {31'b0, tx_strobe}, 32'h1);
        check("R10", "tx byte", {24'b0, tx_byte}, 32'h0000_00C3);
        @(negedge clk);
        #1 check("R10", "strobe one cycle only", {31'b0, tx_strobe}, 32'h0);

        // R11 partial byte enables
        bus_be = 4'h1;
        bus_write(8'h44, 32'h0000_0002);
        bus_read(8'h44, rd);
        check("R11", "partial read zero", rd, 32'h0);
        bus_be = 4'hF;
        bus_read(8'h44, rd);
        check("R11", "partial write ignored", rd, 32'h0000_00C1);
        bus_write(8'h5C, 32'hFFFF_FFFF);
        bus_read(8'h5C, rd);
        check("R11", "scratch offset zero", rd, 32'h0);

        // R1 reset in mid-operation
        push(8'h99);
        bus_write(8'h44, 32'h3);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_read(8'h64, rd);
        check("R1", "buffer empty after reset", rd, 32'h0000_030E);
        bus_read(8'h44, rd);
        check("R1", "enables cleared", rd, 32'h0000_00C0);
        bus_read(8'h54, rd);
        check("R1", "line status after reset", rd, 32'h0000_0060);
        #1 check("R1", "irq low after reset", {31'b0, irq}, 32'h0);
        check("R1", "ready after reset", {31'b0, rx_ready}, 32'h1);

        finish_run();
    end
endmodule